// File: doc/BRIEF.md
# Serial Packet Input Port Receiver

This block terminates one bit-serial input of a packet router. A sender marks a packet by pulling an active-low frame strobe low and holding it low for the whole packet. The data line carries a fixed header: four destination address bits sent lowest bit first, one marker cycle, then three padding cycles. The receiver takes the address whether or not a connection exists, so the header never waits. After the fourth address bit it raises a connection request that carries the destination.

An outside arbiter answers with a grant. The receiver shows the grant to the sender through an active-high "ready" line named `busy_n`; it is low when the port is busy. Once the grant is seen, `busy_n` stays high until the frame ends. In the payload phase a bit is taken only on a cycle where `busy_n` is high and the active-low valid strobe is low. Accepted bits are packed lowest bit first into bytes for the output stage. The frame strobe rises together with the last payload bit. At that point the receiver reports the end of the frame and any partial final byte.

If the frame strobe rises before the header is complete, the frame is dropped and an error pulse is raised.

Top module: `serial_rx_port`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the next cycle shows `busy_n`=0, `req`=0, `byte_vld`=0, `frame_done`=0 and `hdr_err`=0.
- R2: A frame starts on a cycle where `frame_n` is 0 and was 1 on the previous cycle. That cycle and the next three carry address bits 0,1,2,3 on `din`. `req` is 1 from the cycle after the fourth address bit through the last payload cycle, with `req_addr` equal to the captured address, and 0 on the cycle after.
- R3: The marker cycle and the three padding cycles that follow the address are ignored: no bit of `din` or `valid_n` in them reaches a byte.
- R4: Address bits are captured whatever the values of `grant` and `busy_n`.
- R5: In the payload phase a bit is accepted only on a cycle with `busy_n`=1 and `valid_n`=0.
- R6: `busy_n` rises the cycle after a cycle in which `req` and `grant` are both 1. It stays 1 regardless of `grant` until the frame ends, and is 0 on the cycle after the last payload cycle or a header abort.
- R7: Accepted bits fill a byte from bit 0 upward. On the cycle after every eighth accepted bit of a frame, `byte_vld` pulses for one cycle with the byte on `byte_data`.
- R8: A payload cycle with `frame_n`=1 is the last one, and its bit is accepted under R5. On the next cycle `frame_done` pulses and `tail_bits` gives the count of accepted bits mod 8. When that count is nonzero, `byte_data` holds the leftover bits in its low positions with zeros above.
- R9: If `frame_n` is 1 during the second to eighth cycle of a frame, the frame is dropped. On the next cycle `hdr_err` pulses with `req`=0 and `busy_n`=0, no `frame_done` follows, and the next frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | Frame strobe, active low |
| valid_n | input | 1 | Payload valid strobe, active low |
| din | input | 1 | Serial data line |
| grant | input | 1 | Connection grant from the arbiter |
| busy_n | output | 1 | Port ready; low while busy or not granted |
| req | output | 1 | Connection request |
| req_addr | output | 4 | Requested destination |
| byte_vld | output | 1 | Full byte pulse |
| byte_data | output | 8 | Packed byte, first bit in bit 0 |
| frame_done | output | 1 | End-of-frame pulse |
| tail_bits | output | 3 | Bits in the final partial byte (0 = none) |
| hdr_err | output | 1 | Header abort pulse |

## Verification
The hardest case is a grant that arrives part way through the payload. Valid bits sent before `busy_n` rises must then be dropped, and later ones kept, even after the grant falls again. The random frames draw the grant cycle from a range that covers the header, the payload and points past the frame end. They also draw the grant release from a range that reaches into the payload. The expected bit stream is built from the cycle-by-cycle busy state that the requirements predict. Header aborts are forced at early and late header positions with the grant already held, so a connection made in the padding must also be torn down.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int ADDR_W_DEF  = 4;
    localparam int PAD_CYC_DEF = 3;
    localparam int BYTE_W_DEF  = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_MARK,
        PH_PAD,
        PH_DATA
    } rx_phase_e;

    // one payload-cycle command from the header sequencer to the packer
    typedef struct packed {
        logic take;   // bit accepted this cycle
        logic bitv;   // value of the data line
        logic last;   // frame ends this cycle
    } pk_cmd_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/srx_hdr_seq.sv
module srx_hdr_seq
    import srx_pkg::*;
#(
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int PAD_CYC = PAD_CYC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              din,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic              hdr_err,
    output logic              in_data,
    output logic              stop,
    output logic              frame_end
);
    localparam int CW = $clog2(imax(ADDR_W, PAD_CYC) + 1);

    rx_phase_e       phase;
    logic [CW-1:0]   cnt;
    logic            prev_fn;

    assign stop      = frame_n && (phase != PH_IDLE);
    assign frame_end = stop && (phase == PH_DATA);
    assign in_data   = (phase == PH_DATA);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            prev_fn <= 1'b1;
            req     <= 1'b0;
            addr    <= '0;
            hdr_err <= 1'b0;
        end else begin
            prev_fn <= frame_n;
            hdr_err <= 1'b0;
            if (stop) begin
                phase   <= PH_IDLE;
                req     <= 1'b0;
                hdr_err <= (phase != PH_DATA);
            end else begin
                unique case (phase)
                    PH_IDLE: if (!frame_n && prev_fn) begin
                        addr  <= {din, addr[ADDR_W-1:1]};
                        cnt   <= CW'(1);
                        phase <= PH_ADDR;
                    end
                    PH_ADDR: begin
                        addr <= {din, addr[ADDR_W-1:1]};
                        if (cnt == CW'(ADDR_W - 1)) begin
                            phase <= PH_MARK;
                            req   <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_MARK: begin
                        phase <= PH_PAD;
                        cnt   <= '0;
                    end
                    PH_PAD: begin
                        if (cnt == CW'(PAD_CYC - 1)) phase <= PH_DATA;
                        else                          cnt   <= cnt + 1'b1;
                    end
                    PH_DATA: ;
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // R9: an abort pulse never coexists with a live request
    a_r9_err_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |-> !req);

    // R2: the destination does not move while the request is held
    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (!req || $stable(addr)));

endmodule

// File: rtl/srx_conn.sv
module srx_conn (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic grant,
    input  logic stop,
    output logic busy_n
);
    logic conn;

    always_ff @(posedge clk) begin
        if (!rst_n)             conn <= 1'b0;
        else if (stop)          conn <= 1'b0;
        else if (req && grant)  conn <= 1'b1;
    end

    assign busy_n = conn;

    // R6: a made connection survives until the frame stops
    a_r6_conn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (conn && !stop) |=> conn);

    // R6: ready only while a request is outstanding
    a_r6_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        conn |-> req);

endmodule

// File: rtl/srx_packer.sv
module srx_packer
    import srx_pkg::*;
#(
    parameter int BYTE_W = BYTE_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  pk_cmd_t                    cmd,
    output logic                       byte_vld,
    output logic [BYTE_W-1:0]          byte_data,
    output logic                       frame_done,
    output logic [$clog2(BYTE_W)-1:0]  tail_bits
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sr, nxt_sr;
    logic [CNT_W-1:0]  cnt, nxt_cnt;
    logic              full;
    logic [CNT_W:0]    sh;

    always_comb begin
        full    = cmd.take && (cnt == CNT_W'(BYTE_W - 1));
        nxt_sr  = cmd.take ? {cmd.bitv, sr[BYTE_W-1:1]} : sr;
        nxt_cnt = cmd.take ? cnt + 1'b1 : cnt;
        sh      = (CNT_W+1)'(BYTE_W) - {1'b0, nxt_cnt};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr         <= '0;
            cnt        <= '0;
            byte_vld   <= 1'b0;
            byte_data  <= '0;
            frame_done <= 1'b0;
            tail_bits  <= '0;
        end else begin
            byte_vld   <= full;
            frame_done <= cmd.last;
            sr         <= nxt_sr;
            cnt        <= nxt_cnt;
            if (full) byte_data <= nxt_sr;
            if (cmd.last) begin
                tail_bits <= nxt_cnt;
                if (nxt_cnt != '0) byte_data <= nxt_sr >> sh;
                sr  <= '0;
                cnt <= '0;
            end
        end
    end

    // R7: full bytes are at least eight accepted bits apart
    a_r7_byte_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);

    // R8: a partial tail and a full byte never share a cycle
    a_r8_tail_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && tail_bits != '0) |-> !byte_vld);

endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port
    import srx_pkg::*;
#(
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int PAD_CYC = PAD_CYC_DEF,
    parameter int BYTE_W  = BYTE_W_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_n,
    input  logic                      valid_n,
    input  logic                      din,
    input  logic                      grant,
    output logic                      busy_n,
    output logic                      req,
    output logic [ADDR_W-1:0]         req_addr,
    output logic                      byte_vld,
    output logic [BYTE_W-1:0]         byte_data,
    output logic                      frame_done,
    output logic [$clog2(BYTE_W)-1:0] tail_bits,
    output logic                      hdr_err
);
    logic    in_data, stop, frame_end;
    pk_cmd_t cmd;

    srx_hdr_seq #(.ADDR_W(ADDR_W), .PAD_CYC(PAD_CYC)) u_hdr (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .din(din),
        .req(req), .addr(req_addr), .hdr_err(hdr_err),
        .in_data(in_data), .stop(stop), .frame_end(frame_end)
    );

    srx_conn u_conn (
        .clk(clk), .rst_n(rst_n), .req(req), .grant(grant),
        .stop(stop), .busy_n(busy_n)
    );

    always_comb begin
        cmd.take = in_data && busy_n && !valid_n;
        cmd.bitv = din;
        cmd.last = frame_end;
    end

    srx_packer #(.BYTE_W(BYTE_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .cmd(cmd),
        .byte_vld(byte_vld), .byte_data(byte_data),
        .frame_done(frame_done), .tail_bits(tail_bits)
    );

    // R1: reset leaves the port idle and not ready
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy_n && !req && !byte_vld && !frame_done && !hdr_err));

    // R5: a completed byte implies its last bit came while ready and valid
    a_r5_byte_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(busy_n && !valid_n));

endmodule

// File: tb/serial_rx_port_tb.sv
`timescale 1ns/1ps
module serial_rx_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_n, valid_n, din, grant;
    logic       busy_n, req, byte_vld, frame_done, hdr_err;
    logic [3:0] req_addr;
    logic [7:0] byte_data;
    logic [2:0] tail_bits;

    int nchk = 0;
    int nerr = 0;

    logic [7:0] got_bytes[$];
    int         got_done;
    int         got_err;
    logic [2:0] got_tail;
    logic [7:0] got_part;

    always #4 clk = ~clk;

    serial_rx_port dut_i (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .valid_n(valid_n),
        .din(din), .grant(grant), .busy_n(busy_n), .req(req),
        .req_addr(req_addr), .byte_vld(byte_vld), .byte_data(byte_data),
        .frame_done(frame_done), .tail_bits(tail_bits), .hdr_err(hdr_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (byte_vld)   got_bytes.push_back(byte_data);
        if (frame_done) begin got_done++; got_tail = tail_bits; got_part = byte_data; end
        if (hdr_err)    got_err++;
    endtask

    task automatic clear_obs();
        got_bytes.delete();
        got_done = 0;
        got_err  = 0;
    endtask

    function automatic int gmax4(input int g);
        return (g > 4) ? g : 4;
    endfunction

    // n payload cycles, grant raised at cycle g and released at cycle gd,
    // valid low with probability vp percent
    task automatic run_frame(input logic [3:0] a, input int n, input int g,
                             input int gd, input int vp);
        logic bits[64];
        logic vln[64];
        logic acc[$];
        int   last_c = 8 + n - 1;
        int   gm = gmax4(g);
        int   nb;
        logic [7:0] eb;
        logic       eb_busy;
        clear_obs();
        for (int j = 0; j < n; j++) begin
            bits[j] = 1'($urandom);
            vln[j]  = (($urandom % 100) < vp) ? 1'b0 : 1'b1;
        end
        for (int c = 0; c <= last_c + 1; c++) begin
            step();
            eb_busy = (c >= gm + 1) && (c <= last_c);
            chk("R6 busy_n", busy_n, eb_busy);
            if (c >= 1) chk("R2 req", req, (c >= 4) && (c <= last_c));
            if (c == 4) chk("R2/R4 req_addr", req_addr, a);
            if (c <= 8) chk("R3 no byte from header", got_bytes.size(), 0);
            if (c >= 8 && c <= last_c && eb_busy && !vln[c-8]) acc.push_back(bits[c-8]);
            grant   <= (c >= g) && (c < gd) && (c <= last_c);
            frame_n <= (c < last_c) ? 1'b0 : 1'b1;
            if (c < 4)           din <= a[c];
            else if (c == 4)     din <= 1'b1;
            else if (c < 8)      din <= 1'($urandom);
            else if (c <= last_c) din <= bits[c-8];
            else                 din <= 1'b0;
            if (c < 8)            valid_n <= 1'($urandom);
            else if (c <= last_c) valid_n <= vln[c-8];
            else                  valid_n <= 1'b1;
        end
        nb = acc.size() / 8;
        chk("R7 byte count", got_bytes.size(), nb);
        for (int k = 0; k < nb && k < got_bytes.size(); k++) begin
            for (int i = 0; i < 8; i++) eb[i] = acc[8*k + i];
            chk("R7 byte value", got_bytes[k], eb);
        end
        chk("R8 frame_done count", got_done, 1);
        chk("R8 tail_bits", got_tail, acc.size() % 8);
        if (acc.size() % 8 != 0) begin
            eb = '0;
            for (int i = 0; i < acc.size() % 8; i++) eb[i] = acc[8*nb + i];
            chk("R8 partial byte", got_part, eb);
        end
        chk("R9 no spurious hdr_err", got_err, 0);
    endtask

    task automatic run_abort(input logic [3:0] a, input int k);
        clear_obs();
        for (int c = 0; c <= k + 2; c++) begin
            step();
            if (c == k + 1) begin
                chk("R9 hdr_err pulse", hdr_err, 1);
                chk("R9 req dropped", req, 0);
                chk("R9 busy_n low", busy_n, 0);
            end
            if (c == k + 2) chk("R9 hdr_err single", hdr_err, 0);
            grant   <= (c <= k);
            frame_n <= (c < k) ? 1'b0 : 1'b1;
            din     <= (c < 4) ? a[c] : 1'b1;
            valid_n <= 1'b0;
        end
        chk("R9 no frame_done", got_done, 0);
        chk("R9 no bytes", got_bytes.size(), 0);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        nerr++;
        nchk++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        rst_n = 1'b0; frame_n = 1'b1; valid_n = 1'b1; din = 1'b0; grant = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy_n", busy_n, 0);
        chk("R1 req", req, 0);
        chk("R1 byte_vld", byte_vld, 0);
        chk("R1 frame_done", frame_done, 0);
        chk("R1 hdr_err", hdr_err, 0);

        // directed corners
        run_frame(4'hA, 8, 0, 100, 100);   // exactly one byte, tail 0 (R7, R8)
        run_frame(4'h3, 1, 4, 100, 100);   // single payload bit on the end cycle
        run_frame(4'h5, 16, 13, 15, 100);  // grant mid-payload, released (R5, R6)
        run_frame(4'hC, 12, 30, 40, 100);  // never granted: nothing accepted
        run_abort(4'h9, 2);                // early abort
        run_abort(4'h6, 6);                // abort after connection made
        run_frame(4'hF, 11, 2, 20, 70);    // recovery after abort

        // random frames
        for (int f = 0; f < 60; f++) begin
            int g, gd, n;
            n  = 1 + int'($urandom % 40);
            g  = int'($urandom % (n + 12));
            gd = gmax4(g) + 1 + int'($urandom % 20);
            run_frame(4'($urandom), n, g, gd, 30 + int'($urandom % 71));
            if (($urandom % 8) == 0) run_abort(4'($urandom), 1 + int'($urandom % 7));
        end

        // mid-frame reset returns to idle (R1)
        frame_n <= 1'b0; grant <= 1'b1; valid_n <= 1'b0;
        repeat (7) @(negedge clk);
        rst_n <= 1'b0;
        @(negedge clk);
        chk("R1 busy_n after mid-frame reset", busy_n, 0);
        chk("R1 req after mid-frame reset", req, 0);
        rst_n <= 1'b1; frame_n <= 1'b1; grant <= 1'b0;
        @(negedge clk);

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule